// File: doc/BRIEF.md
# Hang-up and stack-fault reset supervisor

This block watches over a small controller and requests a reset when it detects one of two faults. It keeps one interval counter that advances on a prescaled tick. Every time that counter wraps, it raises a one-cycle interval interrupt request. The same wraps also feed a watchdog window. If software does not send a restart strobe before a set number of wraps, the block asserts its active-low reset request.

A second monitor tracks call and interrupt nesting from push and pop events. Nesting deeper than the permitted maximum causes a reset request. So does a return taken at depth zero.

The reset request is held low for a fixed number of clock cycles, and every internal counter is cleared while it is low. When the output is looped back to the reset input, execution restarts from address 0. An external synchronous reset clears everything at once.

Top module: `hang_supervisor`

## Requirements
- R1: The interval counter is `CNT_W` bits wide (default 4). It advances by one on each selected tick. When it wraps from all ones to zero, `ivl_irq` is high for exactly one cycle, in the cycle after the wrapping tick. With the default width, that is the 16th tick after the counter was last zero.
- R2: When `tick_sel` is 0, only `tick_a` advances the counter. When `tick_sel` is 1, only `tick_b` advances it.
- R3: `ivl_clr` zeroes the interval counter and takes priority over a tick in the same cycle. The next interrupt therefore follows 2^`CNT_W` further ticks.
- R4: A reset is requested on the `WDT_LIMIT`-th counter wrap (default 4) since the last restart or reset. `wdt_kick` zeroes the wrap count. A kick in the same cycle as the final wrap wins, and no reset is requested.
- R5: A push with no pop while `depth` equals `MAX_DEPTH` (default 5) requests a reset.
- R6: A pop with no push while `depth` is 0 requests a reset.
- R7: A push and a pop in the same cycle leave `depth` unchanged and request no reset, even at depth 0 or at `MAX_DEPTH`.
- R8: A reset request drives `rst_req_n` low from the cycle after the fault for exactly `HOLD_CYC` cycles (default 16). While it is low, the interval counter, the wrap count, `depth` and `ivl_irq` are held at 0 and all strobes are ignored. They are still 0 after release.
- R9: `rst` is synchronous and active high. It clears all state, releases `rst_req_n` to 1 even in the middle of a hold, and leaves `depth` and `ivl_irq` at 0.
- R10: `depth` rises by one on a lone push and falls by one on a lone pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (external or looped back) |
| tick_a | input | 1 | Prescaled tick, source 0 |
| tick_b | input | 1 | Prescaled tick, source 1 |
| tick_sel | input | 1 | Selects the tick source for the interval counter |
| wdt_kick | input | 1 | Watchdog restart strobe |
| ivl_clr | input | 1 | Interval counter clear strobe |
| push | input | 1 | Call or interrupt entry event |
| pop | input | 1 | Return event |
| rst_req_n | output | 1 | Active-low reset request |
| ivl_irq | output | 1 | Interval interrupt request pulse |
| depth | output | 3 | Current nesting depth |

## Verification
Two pairs of functions can coincide in one cycle, and both are provoked on purpose.

The first pair is the watchdog restart and the wrap that would expire the window. The bench runs the tick for 63 cycles, then raises `wdt_kick` together with the 64th tick. It judges that `rst_req_n` stays high while the interrupt pulse still appears.

The second pair is a push and a pop together. The bench applies them at depth 0 and at full depth. It expects an unchanged `depth` and no reset request.

// File: rtl/hang_sup_pkg.sv
package hang_sup_pkg;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_WDT  = 2'd1,
        FLT_OVF  = 2'd2,
        FLT_UNF  = 2'd3
    } fault_e;

    typedef struct packed {
        logic push;
        logic pop;
    } nest_ev_t;

    function automatic logic is_fault(fault_e f);
        return f != FLT_NONE;
    endfunction

    function automatic fault_e merge_fault(logic wdt, fault_e nest);
        return wdt ? FLT_WDT : nest;
    endfunction

endpackage

// File: rtl/ivl_timer.sv
module ivl_timer #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic clr,
    input  logic tick_a,
    input  logic tick_b,
    input  logic tick_sel,
    input  logic ivl_clr,
    output logic ovf,
    output logic irq
);
    logic [CNT_W-1:0] cnt_q;
    logic             irq_q;
    logic             tick_now;

    always_comb begin
        tick_now = tick_sel ? tick_b : tick_a;
        ovf      = tick_now && !ivl_clr && (cnt_q == {CNT_W{1'b1}});
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            if (ivl_clr)
                cnt_q <= '0;
            else if (tick_now)
                cnt_q <= cnt_q + 1'b1;
            irq_q <= ovf;
        end
    end

    assign irq = irq_q;

    // R1: the interrupt is a single-cycle pulse
    a_r1_irq_single: assert property (@(posedge clk) disable iff (clr)
        irq_q |=> !irq_q);

    // R3: a clear leaves the counter at zero
    a_r3_clear_zero: assert property (@(posedge clk) disable iff (clr)
        ivl_clr |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_window.sv
module wdt_window #(
    parameter int LIMIT = 4,
    parameter int WW    = 3
) (
    input  logic clk,
    input  logic clr,
    input  logic ovf,
    input  logic kick,
    output logic fault
);
    logic [WW-1:0] wcnt_q;

    assign fault = ovf && !kick && (wcnt_q == WW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (clr || kick)
            wcnt_q <= '0;
        else if (ovf)
            wcnt_q <= wcnt_q + 1'b1;
    end

    // R4: the wrap count never reaches the limit
    a_r4_window_range: assert property (@(posedge clk) disable iff (clr)
        wcnt_q < WW'(LIMIT));

    // R4: a restart strobe empties the window
    a_r4_kick_clears: assert property (@(posedge clk) disable iff (clr)
        kick |=> (wcnt_q == '0));
endmodule

// File: rtl/nest_monitor.sv
module nest_monitor
    import hang_sup_pkg::*;
#(
    parameter int MAX_DEPTH = 5,
    parameter int DW        = 3
) (
    input  logic           clk,
    input  logic           clr,
    input  nest_ev_t       ev,
    output logic [DW-1:0]  depth,
    output fault_e         flt
);
    logic [DW-1:0] depth_q;

    always_comb begin
        flt = FLT_NONE;
        if (ev.push && !ev.pop && depth_q == DW'(MAX_DEPTH))
            flt = FLT_OVF;
        else if (ev.pop && !ev.push && depth_q == '0)
            flt = FLT_UNF;
    end

    always_ff @(posedge clk) begin
        if (clr)
            depth_q <= '0;
        else if (ev.push && !ev.pop)
            depth_q <= depth_q + 1'b1;
        else if (ev.pop && !ev.push)
            depth_q <= depth_q - 1'b1;
    end

    assign depth = depth_q;

    // R10: the depth stays within the legal range
    a_r10_depth_range: assert property (@(posedge clk) disable iff (clr)
        depth_q <= DW'(MAX_DEPTH));

    // R7: simultaneous push and pop keep the depth
    a_r7_both_stable: assert property (@(posedge clk) disable iff (clr)
        (ev.push && ev.pop) |=> $stable(depth_q));
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
    parameter int HOLD_CYC = 16,
    parameter int HW       = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fault_in,
    output logic holding
);
    logic [HW-1:0] hcnt_q;
    logic          hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
            hcnt_q <= '0;
        end else if (hold_q) begin
            if (hcnt_q == HW'(HOLD_CYC - 1)) begin
                hold_q <= 1'b0;
                hcnt_q <= '0;
            end else begin
                hcnt_q <= hcnt_q + 1'b1;
            end
        end else if (fault_in) begin
            hold_q <= 1'b1;
            hcnt_q <= '0;
        end
    end

    assign holding = hold_q;

    // R8: a fault starts the hold on the next cycle
    a_r8_hold_start: assert property (@(posedge clk) disable iff (rst)
        (fault_in && !hold_q) |=> hold_q);

    // R8: the hold ends after its last count
    a_r8_hold_end: assert property (@(posedge clk) disable iff (rst)
        (hold_q && hcnt_q == HW'(HOLD_CYC - 1)) |=> !hold_q);

    // R9: reset releases the hold
    a_r9_reset_release: assert property (@(posedge clk)
        rst |=> !hold_q);
endmodule

// File: rtl/hang_supervisor.sv
module hang_supervisor
    import hang_sup_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int WDT_LIMIT = 4,
    parameter int MAX_DEPTH = 5,
    parameter int HOLD_CYC  = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_a,
    input  logic       tick_b,
    input  logic       tick_sel,
    input  logic       wdt_kick,
    input  logic       ivl_clr,
    input  logic       push,
    input  logic       pop,
    output logic       rst_req_n,
    output logic       ivl_irq,
    output logic [2:0] depth
);
    localparam int DW = $clog2(MAX_DEPTH + 1);
    localparam int WW = $clog2(WDT_LIMIT + 1);
    localparam int HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

    logic          ovf, wdt_fault, holding, fault_any, clr_all;
    fault_e        nest_flt, flt_now;
    nest_ev_t      ev;
    logic [DW-1:0] depth_i;

    assign ev        = '{push: push, pop: pop};
    assign flt_now   = merge_fault(wdt_fault, nest_flt);
    assign fault_any = !holding && is_fault(flt_now);
    assign clr_all   = rst || holding || fault_any;

    ivl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .clr(clr_all), .tick_a(tick_a), .tick_b(tick_b),
        .tick_sel(tick_sel), .ivl_clr(ivl_clr), .ovf(ovf), .irq(ivl_irq)
    );

    wdt_window #(.LIMIT(WDT_LIMIT), .WW(WW)) u_wdt (
        .clk(clk), .clr(clr_all), .ovf(ovf), .kick(wdt_kick), .fault(wdt_fault)
    );

    nest_monitor #(.MAX_DEPTH(MAX_DEPTH), .DW(DW)) u_nest (
        .clk(clk), .clr(clr_all), .ev(ev), .depth(depth_i), .flt(nest_flt)
    );

    rst_stretch #(.HOLD_CYC(HOLD_CYC), .HW(HW)) u_hold (
        .clk(clk), .rst(rst), .fault_in(fault_any), .holding(holding)
    );

    assign rst_req_n = !holding;
    assign depth     = 3'(depth_i);

    // R5: a push at full depth requests a reset
    a_r5_overflow: assert property (@(posedge clk) disable iff (rst)
        (rst_req_n && push && !pop && depth == 3'(MAX_DEPTH)) |=> !rst_req_n);

    // R6: a pop at depth zero requests a reset
    a_r6_underflow: assert property (@(posedge clk) disable iff (rst)
        (rst_req_n && pop && !push && depth == 3'd0) |=> !rst_req_n);

    // R8: everything reads zero while the reset request is low
    a_r8_quiet_hold: assert property (@(posedge clk) disable iff (rst)
        !rst_req_n |-> (depth == 3'd0 && !ivl_irq));
endmodule

// File: tb/tb_hang_supervisor.sv
module tb_hang_supervisor;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_a = 0, tick_b = 0, tick_sel = 0, wdt_kick = 0, ivl_clr = 0;
    logic push = 0, pop = 0;
    logic rst_req_n, ivl_irq;
    logic [2:0] depth;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    hang_supervisor dut (
        .clk(clk), .rst(rst), .tick_a(tick_a), .tick_b(tick_b),
        .tick_sel(tick_sel), .wdt_kick(wdt_kick), .ivl_clr(ivl_clr),
        .push(push), .pop(pop), .rst_req_n(rst_req_n), .ivl_irq(ivl_irq),
        .depth(depth)
    );

    // {push, pop, expected depth}
    localparam logic [4:0] VEC [0:15] = '{
        5'b10_001, 5'b10_010, 5'b10_011, 5'b01_010,
        5'b11_010, 5'b10_011, 5'b10_100, 5'b10_101,
        5'b11_101, 5'b01_100, 5'b01_011, 5'b01_010,
        5'b01_001, 5'b01_000, 5'b11_000, 5'b00_000
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic edge1();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        edge1();
        edge1();
        rst = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        int lows;
        bit bad;

        // R9: reset state
        do_reset();
        chk(rst_req_n == 1'b1, "R9 reset rst_req_n", rst_req_n, 1);
        chk(depth == 3'd0, "R9 reset depth", depth, 0);
        chk(ivl_irq == 1'b0, "R9 reset irq", ivl_irq, 0);

        // R10 / R7: table of nesting events
        for (int i = 0; i < 16; i++) begin
            push = VEC[i][4];
            pop  = VEC[i][3];
            edge1();
            chk(depth == VEC[i][2:0], "R10/R7 depth vector", depth, VEC[i][2:0]);
            chk(rst_req_n == 1'b1, "R7 no fault vector", rst_req_n, 1);
        end
        push = 0; pop = 0;

        // R5 overflow, R8 hold length and ignored strobes
        for (int i = 0; i < 5; i++) begin push = 1; edge1(); end
        chk(depth == 3'd5, "R10 full depth", depth, 5);
        edge1();
        chk(rst_req_n == 1'b0, "R5 overflow reset", rst_req_n, 0);
        chk(depth == 3'd0, "R8 depth cleared", depth, 0);
        lows = 1;
        n = 0;
        while (!rst_req_n && n < 40) begin
            edge1();
            n++;
            if (!rst_req_n) lows++;
        end
        chk(lows == 16, "R8 hold length", lows, 16);
        chk(depth == 3'd0, "R8 push ignored in hold", depth, 0);
        push = 0;
        edge1();
        chk(depth == 3'd0 && rst_req_n, "R8 state zero after release", depth, 0);

        // R6 underflow, then R9 reset during hold
        pop = 1;
        edge1();
        pop = 0;
        chk(rst_req_n == 1'b0, "R6 underflow reset", rst_req_n, 0);
        edge1();
        rst = 1;
        edge1();
        rst = 0;
        chk(rst_req_n == 1'b1, "R9 reset ends hold", rst_req_n, 1);

        // R1 interrupt timing, R4 watchdog expiry
        do_reset();
        tick_sel = 0;
        tick_a = 1;
        bad = 0;
        for (int i = 1; i <= 15; i++) begin edge1(); if (ivl_irq) bad = 1; end
        chk(!bad, "R1 no early irq", bad, 0);
        edge1();
        chk(ivl_irq == 1'b1, "R1 irq after 16 ticks", ivl_irq, 1);
        edge1();
        chk(ivl_irq == 1'b0, "R1 irq one cycle", ivl_irq, 0);
        n = 17;
        while (rst_req_n && n < 200) begin edge1(); n++; end
        chk(n == 64, "R4 watchdog expiry cycle", n, 64);
        tick_a = 0;
        do_reset();

        // R4 kick on the same cycle as the final wrap
        tick_a = 1;
        for (int i = 0; i < 63; i++) edge1();
        wdt_kick = 1;
        edge1();
        wdt_kick = 0;
        chk(rst_req_n == 1'b1, "R4 kick wins on last wrap", rst_req_n, 1);
        chk(ivl_irq == 1'b1, "R1 irq alongside kick", ivl_irq, 1);
        bad = 0;
        for (int i = 0; i < 60; i++) begin edge1(); if (!rst_req_n) bad = 1; end
        chk(!bad, "R4 window restarted", bad, 0);
        tick_a = 0;
        do_reset();

        // R2 source select
        tick_sel = 1;
        tick_a = 1;
        tick_b = 0;
        bad = 0;
        for (int i = 0; i < 40; i++) begin edge1(); if (ivl_irq) bad = 1; end
        chk(!bad, "R2 unselected tick ignored", bad, 0);
        tick_b = 1;
        for (int i = 0; i < 16; i++) edge1();
        chk(ivl_irq == 1'b1, "R2 selected tick counts", ivl_irq, 1);
        tick_a = 0; tick_b = 0; tick_sel = 0;
        do_reset();

        // R3 clear overrides a tick
        tick_a = 1;
        for (int i = 0; i < 9; i++) edge1();
        ivl_clr = 1;
        edge1();
        ivl_clr = 0;
        bad = 0;
        for (int i = 0; i < 15; i++) begin edge1(); if (ivl_irq) bad = 1; end
        chk(!bad, "R3 no irq before 16 ticks", bad, 0);
        edge1();
        chk(ivl_irq == 1'b1, "R3 irq 16 ticks after clear", ivl_irq, 1);
        tick_a = 0;

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule